// File: doc/BRIEF.md
# Partitioned Cache Victim Selector with Capacity Borrowing

This block decides which way of one set of a shared, set-associative cache is replaced on a miss. The ways of every set are split evenly and statically among the cores: with `NUM_WAYS` ways and `NUM_CORES` cores, core c owns the contiguous group of `NUM_WAYS/NUM_CORES` ways starting at way c·(`NUM_WAYS/NUM_CORES`). A core may still place a line in a way owned by another core. That is a borrowed placement, and the block remembers every one of them so that the owner can reclaim its way later.

A miss handler presents a request for one cycle. The request carries the requesting core, the set index and the `NUM_CAND` lowest-priority ways of the set, in order of priority. For each of these candidates it also gives the way number, the core that placed the line now in it and that line's access-frequency counter. The block applies three rules in order. First, it evicts one of the requester's own lines. Failing that, it reclaims one of the requester's ways that another core has borrowed. Failing that, it evicts the candidate with the lowest frequency, which may start a new borrowed placement. The victim is reported one cycle later, together with a code for the rule that fired. The borrowing record is updated on the same clock edge.

The request path has no back-pressure: a request is accepted in every cycle in which `req_valid` is high, and each one gives exactly one result. The core-pair summary of the borrowing record is visible on `steal_pairs`.

Top module: `fvs_victim_select`

## Requirements
- R1: Way w is owned by core w / (NUM_WAYS/NUM_CORES); with the defaults, ways 0-3 belong to core 0, ways 4-7 to core 1, ways 8-11 to core 2 and ways 12-15 to core 3.
- R2: `vic_valid` is high in exactly the cycle after each cycle with `req_valid` high, and low otherwise; no request is ever refused.
- R3: When at least one candidate's line owner equals `req_core`, the victim is such a candidate and `vic_rule` is 1.
- R4: Among several candidates that qualify under R3, the one with the lowest frequency wins. Equal frequencies go to the lower candidate position (position 0, bits [WAY_W-1:0] of `cand_way`, is the lowest priority).
- R5: When R3 does not apply and the record holds a borrowed line in a way of the requester's partition in this set, the lowest-numbered such way is the victim, `vic_rule` is 2 and that record entry is removed.
- R6: When neither R3 nor R5 applies, the candidate with the lowest frequency is the victim, with ties going to the lower position, and `vic_rule` is 3.
- R7: When R6 picks a way outside the requester's partition, the block records a borrowed placement for that set and way, and bit (requester·NUM_CORES + way owner) of `steal_pairs` becomes 1. A way inside the requester's own partition is never recorded.
- R8: Any eviction removes the record entry previously held by the evicted way, whichever rule chose it.
- R9: A bit of `steal_pairs` stays 1 as long as any set still holds a borrowed placement for that core pair, and clears when the last one is removed.
- R10: After reset, `vic_valid` is 0, `steal_pairs` is 0 and the record is empty.
- R11: Cycles without a request leave the record and `steal_pairs` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle victim request strobe |
| req_core | input | CORE_W | Requesting core |
| req_set | input | SET_W | Set index |
| cand_way | input | NUM_CAND*WAY_W | Candidate way numbers, position 0 in the low bits |
| cand_owner | input | NUM_CAND*CORE_W | Core that placed each candidate's line |
| cand_freq | input | NUM_CAND*FREQ_W | Access-frequency counter of each candidate |
| vic_valid | output | 1 | Victim result valid |
| vic_way | output | WAY_W | Chosen victim way |
| vic_rule | output | 2 | Rule that fired: 1 own line, 2 reclaim, 3 lowest frequency |
| steal_pairs | output | NUM_CORES*NUM_CORES | Bit t·NUM_CORES+o set while core t holds a line in a way of core o |

## Verification
On every cycle, the assertions check the one-cycle result timing and that a request with any own-line candidate always ends in rule 1 on one of those lines. They also check that a reclaimed way lies in the requester's partition, that a borrowing eviction leaves its core-pair bit set, and that the pair summary never moves without a request. Other behaviours need long, deliberate sequences across many requests, and only the directed scenarios show them. These are the choice of the lowest-numbered of several borrowed ways and the tie-breaks on frequency and position. They also include pair bits that persist across sets until the last placement goes, and a borrowed placement silently dropped when a later lowest-frequency eviction or the borrower itself takes the way.

// File: rtl/fvs_pkg.sv
package fvs_pkg;
  // Which selection rule produced a victim.
  typedef enum logic [1:0] {
    RULE_NONE    = 2'd0,
    RULE_OWN     = 2'd1,
    RULE_RECLAIM = 2'd2,
    RULE_LOWFREQ = 2'd3
  } rule_e;
endpackage

// File: rtl/fvs_argmin.sv
// Lowest-frequency search over the candidates enabled by mask.
// Ties go to the lower position because only a strictly smaller value replaces the current best.
module fvs_argmin #(
  parameter int M      = 4,
  parameter int FREQ_W = 8,
  parameter int IDX_W  = 2
) (
  input  logic [M-1:0]        mask,
  input  logic [M*FREQ_W-1:0] freq,
  output logic                found,
  output logic [IDX_W-1:0]    idx
);
  logic [FREQ_W-1:0] best;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '0;
    for (int p = 0; p < M; p++) begin
      if (mask[p] && (!found || (freq[p*FREQ_W +: FREQ_W] < best))) begin
        found = 1'b1;
        idx   = IDX_W'(p);
        best  = freq[p*FREQ_W +: FREQ_W];
      end
    end
  end
endmodule

// File: rtl/fvs_reclaim_scan.sv
// Finds the lowest way in the requester's partition that holds a line borrowed by another core.
module fvs_reclaim_scan #(
  parameter int N      = 4,
  parameter int L      = 16,
  parameter int CORE_W = 2,
  parameter int WAY_W  = 4
) (
  input  logic [CORE_W-1:0]   req_core,
  input  logic [L-1:0]        row_v,
  input  logic [L*CORE_W-1:0] row_by,
  input  logic [N*N-1:0]      pair_flags,
  output logic                found,
  output logic [WAY_W-1:0]    way
);
  localparam int WPC = L / N;

  always_comb begin
    found = 1'b0;
    way   = '0;
    for (int w = 0; w < L; w++) begin
      if (!found && row_v[w] && (CORE_W'(w / WPC) == req_core) &&
          pair_flags[int'(row_by[w*CORE_W +: CORE_W]) * N + (w / WPC)]) begin
        found = 1'b1;
        way   = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/fvs_steal_table.sv
// Per-set, per-way record of borrowed placements plus per-core-pair occupancy counts.
module fvs_steal_table #(
  parameter int N      = 4,
  parameter int L      = 16,
  parameter int SETS   = 16,
  parameter int CORE_W = 2,
  parameter int WAY_W  = 4,
  parameter int SET_W  = 4,
  parameter int CNT_W  = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                evict_en,
  input  logic [SET_W-1:0]    set_idx,
  input  logic [WAY_W-1:0]    evict_way,
  input  logic                steal_en,
  input  logic [CORE_W-1:0]   steal_core,
  output logic [L-1:0]        rd_v,
  output logic [L*CORE_W-1:0] rd_by,
  output logic [N*N-1:0]      pair_flags
);
  localparam int WPC   = L / N;
  localparam int PAIRS = N * N;

  logic [L-1:0]        tv    [SETS];
  logic [L*CORE_W-1:0] tby   [SETS];
  logic [CNT_W-1:0]    cnt   [PAIRS];

  logic              old_v;
  logic [CORE_W-1:0] old_by;
  int                way_own;
  int                dec_idx;
  int                inc_idx;
  logic [PAIRS-1:0]  inc_vec;
  logic [PAIRS-1:0]  dec_vec;

  assign rd_v  = tv[set_idx];
  assign rd_by = tby[set_idx];

  always_comb begin
    old_v   = tv[set_idx][evict_way];
    old_by  = tby[set_idx][evict_way*CORE_W +: CORE_W];
    way_own = int'(evict_way) / WPC;
    dec_idx = int'(old_by) * N + way_own;
    inc_idx = int'(steal_core) * N + way_own;
    for (int p = 0; p < PAIRS; p++) begin
      dec_vec[p] = evict_en && old_v && (p == dec_idx);
      inc_vec[p] = evict_en && steal_en && (p == inc_idx);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        tv[s]  <= '0;
        tby[s] <= '0;
      end
      for (int p = 0; p < PAIRS; p++) cnt[p] <= '0;
    end else if (evict_en) begin
      tv[set_idx][evict_way] <= steal_en;
      if (steal_en) tby[set_idx][evict_way*CORE_W +: CORE_W] <= steal_core;
      for (int p = 0; p < PAIRS; p++)
        cnt[p] <= cnt[p] + CNT_W'(inc_vec[p]) - CNT_W'(dec_vec[p]);
    end
  end

  for (genvar g = 0; g < PAIRS; g++) begin : g_flag
    assign pair_flags[g] = |cnt[g];
  end
endmodule

// File: rtl/fvs_victim_select.sv
module fvs_victim_select #(
  parameter int NUM_CORES = 4,
  parameter int NUM_WAYS  = 16,
  parameter int NUM_SETS  = 16,
  parameter int NUM_CAND  = 4,
  parameter int FREQ_W    = 8,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int WAY_W    = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
  localparam int SET_W    = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic [CORE_W-1:0]             req_core,
  input  logic [SET_W-1:0]              req_set,
  input  logic [NUM_CAND*WAY_W-1:0]     cand_way,
  input  logic [NUM_CAND*CORE_W-1:0]    cand_owner,
  input  logic [NUM_CAND*FREQ_W-1:0]    cand_freq,
  output logic                          vic_valid,
  output logic [WAY_W-1:0]              vic_way,
  output logic [1:0]                    vic_rule,
  output logic [NUM_CORES*NUM_CORES-1:0] steal_pairs
);
  import fvs_pkg::*;

  localparam int WPC   = NUM_WAYS / NUM_CORES;
  localparam int IDX_W = (NUM_CAND > 1) ? $clog2(NUM_CAND) : 1;
  localparam int CNT_W = $clog2(NUM_SETS * WPC + 1);

  logic [NUM_CAND-1:0]          own_mask;
  logic                         own_found, low_found, rec_found;
  logic [IDX_W-1:0]             own_idx, low_idx;
  logic [WAY_W-1:0]             rec_way;
  logic [NUM_WAYS-1:0]          row_v;
  logic [NUM_WAYS*CORE_W-1:0]   row_by;
  rule_e                        pick_rule;
  logic [WAY_W-1:0]             pick_way;
  logic                         steal_en;
  rule_e                        rule_q;

  for (genvar p = 0; p < NUM_CAND; p++) begin : g_own
    assign own_mask[p] = (cand_owner[p*CORE_W +: CORE_W] == req_core);
  end

  fvs_argmin #(.M(NUM_CAND), .FREQ_W(FREQ_W), .IDX_W(IDX_W)) u_own_pick (
    .mask(own_mask), .freq(cand_freq), .found(own_found), .idx(own_idx)
  );

  fvs_argmin #(.M(NUM_CAND), .FREQ_W(FREQ_W), .IDX_W(IDX_W)) u_low_pick (
    .mask({NUM_CAND{1'b1}}), .freq(cand_freq), .found(low_found), .idx(low_idx)
  );

  fvs_reclaim_scan #(.N(NUM_CORES), .L(NUM_WAYS), .CORE_W(CORE_W), .WAY_W(WAY_W)) u_scan (
    .req_core(req_core), .row_v(row_v), .row_by(row_by), .pair_flags(steal_pairs),
    .found(rec_found), .way(rec_way)
  );

  fvs_steal_table #(
    .N(NUM_CORES), .L(NUM_WAYS), .SETS(NUM_SETS), .CORE_W(CORE_W),
    .WAY_W(WAY_W), .SET_W(SET_W), .CNT_W(CNT_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n), .evict_en(req_valid), .set_idx(req_set),
    .evict_way(pick_way), .steal_en(steal_en), .steal_core(req_core),
    .rd_v(row_v), .rd_by(row_by), .pair_flags(steal_pairs)
  );

  // Rule priority: own line, then reclaim a borrowed way, then lowest frequency.
  always_comb begin
    if (own_found) begin
      pick_rule = RULE_OWN;
      pick_way  = cand_way[own_idx*WAY_W +: WAY_W];
    end else if (rec_found) begin
      pick_rule = RULE_RECLAIM;
      pick_way  = rec_way;
    end else begin
      pick_rule = RULE_LOWFREQ;
      pick_way  = cand_way[low_idx*WAY_W +: WAY_W];
    end
    steal_en = req_valid && low_found && (pick_rule == RULE_LOWFREQ) &&
               ((int'(pick_way) / WPC) != int'(req_core));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vic_valid <= 1'b0;
      vic_way   <= '0;
      rule_q    <= RULE_NONE;
    end else begin
      vic_valid <= req_valid;
      if (req_valid) begin
        vic_way <= pick_way;
        rule_q  <= pick_rule;
      end
    end
  end

  assign vic_rule = rule_q;
endmodule

// File: rtl/fvs_victim_select_chk.sv
module fvs_victim_select_chk #(
  parameter int NUM_CORES = 4,
  parameter int NUM_WAYS  = 16,
  parameter int NUM_SETS  = 16,
  parameter int NUM_CAND  = 4,
  parameter int FREQ_W    = 8,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int WAY_W    = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           req_valid,
  input logic [CORE_W-1:0]              req_core,
  input logic [NUM_CAND*WAY_W-1:0]      cand_way,
  input logic [NUM_CAND*CORE_W-1:0]     cand_owner,
  input logic                           vic_valid,
  input logic [WAY_W-1:0]               vic_way,
  input logic [1:0]                     vic_rule,
  input logic [NUM_CORES*NUM_CORES-1:0] steal_pairs
);
  localparam int WPC = NUM_WAYS / NUM_CORES;

  logic [CORE_W-1:0]          prev_core;
  logic [NUM_CAND*WAY_W-1:0]  prev_way;
  logic [NUM_CAND*CORE_W-1:0] prev_owner;
  logic                       prev_own_any;
  logic                       prev_own_at_vic;
  logic                       vic_in_home;
  logic                       pair_bit_now;
  int                         vic_part;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_core  <= '0;
      prev_way   <= '0;
      prev_owner <= '0;
    end else if (req_valid) begin
      prev_core  <= req_core;
      prev_way   <= cand_way;
      prev_owner <= cand_owner;
    end
  end

  always_comb begin
    prev_own_any    = 1'b0;
    prev_own_at_vic = 1'b0;
    for (int p = 0; p < NUM_CAND; p++) begin
      if (prev_owner[p*CORE_W +: CORE_W] == prev_core) begin
        prev_own_any = 1'b1;
        if (prev_way[p*WAY_W +: WAY_W] == vic_way) prev_own_at_vic = 1'b1;
      end
    end
    vic_part     = int'(vic_way) / WPC;
    vic_in_home  = (vic_part == int'(prev_core));
    pair_bit_now = steal_pairs[int'(prev_core) * NUM_CORES + vic_part];
  end

  assert_result_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> vic_valid);
  assert_result_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !vic_valid);
  assert_own_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (vic_valid && prev_own_any) |-> (vic_rule == 2'd1));
  assert_own_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (vic_valid && vic_rule == 2'd1) |-> prev_own_at_vic);
  assert_reclaim_home_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (vic_valid && vic_rule == 2'd2) |-> vic_in_home);
  assert_borrow_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vic_valid && vic_rule == 2'd3 && !vic_in_home) |-> pair_bit_now);
  assert_idle_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !vic_valid |-> $stable(steal_pairs));
endmodule

bind fvs_victim_select fvs_victim_select_chk #(
  .NUM_CORES(NUM_CORES), .NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS),
  .NUM_CAND(NUM_CAND), .FREQ_W(FREQ_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_core(req_core),
  .cand_way(cand_way), .cand_owner(cand_owner), .vic_valid(vic_valid),
  .vic_way(vic_way), .vic_rule(vic_rule), .steal_pairs(steal_pairs)
);

// File: tb/fvs_victim_select_tb_top.sv
`timescale 1ns/1ps
module fvs_victim_select_tb_top;
  typedef int quad_t [4];

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_core = '0;
  logic [3:0]  req_set = '0;
  logic [15:0] cand_way = '0;
  logic [7:0]  cand_owner = '0;
  logic [31:0] cand_freq = '0;
  logic        vic_valid;
  logic [3:0]  vic_way;
  logic [1:0]  vic_rule;
  logic [15:0] steal_pairs;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  fvs_victim_select dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_core(req_core),
    .req_set(req_set), .cand_way(cand_way), .cand_owner(cand_owner),
    .cand_freq(cand_freq), .vic_valid(vic_valid), .vic_way(vic_way),
    .vic_rule(vic_rule), .steal_pairs(steal_pairs)
  );

  task automatic check_int(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Drive one request strobe; return at the negedge after the capturing edge.
  task automatic send(input int core, input int set, input quad_t w, input quad_t o, input quad_t f);
    @(negedge clk);
    req_core = 2'(core);
    req_set  = 4'(set);
    for (int p = 0; p < 4; p++) begin
      cand_way[p*4 +: 4]   = 4'(w[p]);
      cand_owner[p*2 +: 2] = 2'(o[p]);
      cand_freq[p*8 +: 8]  = 8'(f[p]);
    end
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_vic(input string tag, input int way, input int rule, input int pairs);
    check_int(tag, "vic_valid", int'(vic_valid), 1);
    check_int(tag, "vic_way", int'(vic_way), way);
    check_int(tag, "vic_rule", int'(vic_rule), rule);
    check_int(tag, "steal_pairs", int'(steal_pairs), pairs);
  endtask

  task automatic t_reset_r10();
    check_int("R10", "vic_valid", int'(vic_valid), 0);
    check_int("R10", "steal_pairs", int'(steal_pairs), 0);
  endtask

  task automatic t_own_line_r3();
    // Own line at position 2 wins despite higher frequency.
    send(0, 0, '{4, 8, 0, 12}, '{1, 2, 0, 3}, '{1, 1, 9, 1});
    expect_vic("R3", 0, 1, 0);
  endtask

  task automatic t_own_tie_r4();
    // Own lines at positions 0,1,2; frequency 4 ties at 1 and 2, lower position wins.
    send(2, 0, '{1, 9, 10, 5}, '{2, 2, 2, 0}, '{7, 4, 4, 0});
    expect_vic("R4", 9, 1, 0);
  endtask

  task automatic t_borrow_and_reclaim_r7_r5();
    // Core 1 evicts lowest frequency (tie pos 1 vs 3) way 8 of core 2: pair bit 1*4+2.
    send(1, 2, '{0, 8, 12, 4}, '{0, 2, 3, 2}, '{9, 2, 7, 2});
    expect_vic("R7", 8, 3, 1 << 6);
    // Core 2 has no own candidate: it reclaims way 8 and the pair bit clears.
    send(2, 2, '{0, 1, 12, 13}, '{0, 0, 3, 3}, '{0, 0, 0, 0});
    expect_vic("R5", 8, 2, 0);
  endtask

  task automatic t_multi_reclaim_r5();
    send(0, 5, '{13, 9, 6, 5}, '{3, 2, 1, 1}, '{0, 5, 5, 5});
    expect_vic("R7", 13, 3, 1 << 3);
    send(0, 5, '{15, 9, 6, 5}, '{3, 2, 1, 1}, '{1, 5, 5, 5});
    expect_vic("R7", 15, 3, 1 << 3);
    send(1, 5, '{12, 9, 2, 3}, '{3, 2, 0, 0}, '{0, 4, 4, 4});
    expect_vic("R7", 12, 3, (1 << 3) | (1 << 7));
    // Core 3 reclaims borrowed ways lowest first: 12, 13, 15.
    send(3, 5, '{0, 4, 8, 9}, '{0, 1, 2, 2}, '{1, 1, 1, 1});
    expect_vic("R5", 12, 2, 1 << 3);
    send(3, 5, '{0, 4, 8, 9}, '{0, 1, 2, 2}, '{1, 1, 1, 1});
    expect_vic("R5", 13, 2, 1 << 3);
    send(3, 5, '{0, 4, 8, 9}, '{0, 1, 2, 2}, '{1, 1, 1, 1});
    expect_vic("R9", 15, 2, 0);
    // Nothing left to reclaim: lowest frequency, tie to position 0.
    send(3, 5, '{0, 4, 8, 9}, '{0, 1, 2, 2}, '{1, 1, 1, 1});
    expect_vic("R6", 0, 3, 1 << 12);
    send(0, 5, '{4, 8, 12, 13}, '{1, 2, 3, 3}, '{0, 0, 0, 0});
    expect_vic("R5", 0, 2, 0);
  endtask

  task automatic t_pair_across_sets_r9();
    send(0, 1, '{4, 8, 12, 13}, '{1, 2, 3, 3}, '{0, 3, 3, 3});
    expect_vic("R9", 4, 3, 1 << 1);
    send(0, 3, '{4, 8, 12, 13}, '{1, 2, 3, 3}, '{0, 3, 3, 3});
    expect_vic("R9", 4, 3, 1 << 1);
    send(1, 1, '{0, 8, 12, 13}, '{0, 2, 3, 3}, '{0, 0, 0, 0});
    expect_vic("R9", 4, 2, 1 << 1);
    send(1, 3, '{0, 8, 12, 13}, '{0, 2, 3, 3}, '{0, 0, 0, 0});
    expect_vic("R9", 4, 2, 0);
  endtask

  task automatic t_overwrite_r8();
    send(0, 7, '{8, 12, 4, 13}, '{2, 3, 1, 3}, '{0, 5, 5, 5});
    expect_vic("R7", 8, 3, 1 << 2);
    // Core 1 takes the same way by lowest frequency: core 0's record goes, core 1's appears.
    send(1, 7, '{8, 12, 0, 13}, '{0, 3, 0, 3}, '{1, 5, 5, 5});
    expect_vic("R8", 8, 3, 1 << 6);
    send(2, 7, '{0, 12, 4, 13}, '{0, 3, 1, 3}, '{0, 0, 0, 0});
    expect_vic("R8", 8, 2, 0);
    // Borrower evicts its own borrowed line by rule 1: record removed.
    send(0, 9, '{8, 12, 4, 13}, '{2, 3, 1, 3}, '{0, 5, 5, 5});
    expect_vic("R7", 8, 3, 1 << 2);
    send(0, 9, '{12, 8, 4, 13}, '{3, 0, 1, 3}, '{0, 9, 0, 0});
    expect_vic("R8", 8, 1, 0);
  endtask

  task automatic t_own_beats_reclaim_r3();
    send(0, 11, '{8, 12, 4, 13}, '{2, 3, 1, 3}, '{0, 5, 5, 5});
    expect_vic("R7", 8, 3, 1 << 2);
    send(2, 11, '{9, 0, 12, 13}, '{2, 0, 3, 3}, '{9, 0, 0, 0});
    expect_vic("R3", 9, 1, 1 << 2);
    send(2, 11, '{0, 12, 13, 1}, '{0, 3, 3, 0}, '{0, 0, 0, 0});
    expect_vic("R5", 8, 2, 0);
  endtask

  task automatic t_home_not_recorded_r7();
    // Way 5 belongs to core 1 (R1): evicting it records nothing.
    send(1, 12, '{0, 5, 8, 12}, '{0, 3, 2, 3}, '{5, 1, 5, 5});
    expect_vic("R1", 5, 3, 0);
    send(1, 12, '{0, 8, 12, 13}, '{0, 2, 3, 3}, '{0, 1, 1, 1});
    expect_vic("R7", 0, 3, 1 << 4);
  endtask

  task automatic t_idle_r2_r11();
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check_int("R2", "vic_valid idle", int'(vic_valid), 0);
      check_int("R11", "steal_pairs idle", int'(steal_pairs), 1 << 4);
    end
    // Decision after idle still sees the record: core 0 reclaims way 0.
    send(0, 12, '{4, 8, 12, 13}, '{1, 2, 3, 3}, '{0, 0, 0, 0});
    expect_vic("R11", 0, 2, 0);
    @(negedge clk);
    check_int("R2", "vic_valid after strobe", int'(vic_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_r10();
    t_own_line_r3();
    t_own_tie_r4();
    t_borrow_and_reclaim_r7_r5();
    t_multi_reclaim_r5();
    t_pair_across_sets_r9();
    t_overwrite_r8();
    t_own_beats_reclaim_r3();
    t_home_not_recorded_r7();
    t_idle_r2_r11();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule